// File: doc/BRIEF.md
# Channel Interrupt Status Unit

This block keeps the interrupt bookkeeping for one DMA channel. The transfer engine sends it single-cycle event pulses, one for a finished transfer and one for an aborted transfer. The unit holds four word-addressed views of those events:

- **Live view:** the events seen on the previous clock.
- **Latched view:** a sticky request register that software clears by writing 1s.
- **Mask:** an enable register.
- **Detect view:** the latched bits ANDed with the mask.

An aborted transfer flags both the abort bit and the done bit. Handler code must therefore inspect the abort bit, or its own state, to tell the two endings apart.

The unit drives one active-high interrupt. It is high whenever the detect view is non-zero, so several channels can share one wire-ORed line. Software reaches the registers through a plain 32-bit port: a 4-bit word offset, a write strobe, write data and a combinational read data bus.

A decode stage maps each offset to a named selection: `SEL_LIVE`, `SEL_LATCH`, `SEL_MASK`, `SEL_DETECT`, or `SEL_NONE` for every other offset. The read multiplexer and the write side effects are both driven from that one selection.

Top module: `chan_irq_unit`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Word offset 4 (byte 0x10) is the live view. It shows bit 1 for a done event and bit 13 for an abort event, for events applied on the previous clock only. It is read-only, and writes to it change nothing.
- R3: A done pulse sets bit 1 of the latched view (word offset 5, byte 0x14) at the next clock. The bit stays set until it is cleared.
- R4: An abort pulse sets both bit 13 and bit 1 of the latched view at the next clock, so that the abort bit can be polled one cycle after the pulse.
- R5: Writing to word offset 5 clears each latched bit whose write-data bit is 1. Data bits that are 0 leave the latched bits unchanged.
- R6: If an event sets a latched bit in the same cycle as a write that clears it, the bit ends up set.
- R7: Word offset 6 (byte 0x18) is the read/write mask. Only bits 1 and 13 are stored, and all other bits read as 0.
- R8: Word offset 7 (byte 0x1C) is the detect view. It equals the latched view ANDed with the mask, and writes to it change nothing.
- R9: `irq` is high exactly when the detect view is non-zero. A zero detect view keeps `irq` low.
- R10: Offsets other than 4 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_evt | input | 1 | One-cycle pulse: transfer finished |
| abort_evt | input | 1 | One-cycle pulse: transfer aborted |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request, active high |

## Verification
A latched bit that is lost or stuck shows up in two places:

- On the next read of offset 5 or 7.
- At once on `irq`, when the mask enables that bit.

A fault in the clear path, such as a lost set-wins priority or a zero data bit acting as a clear, appears one clock after the colliding write. A bad mask or a bad decode stage appears as a non-zero read from an unmapped offset, or as bits other than 1 and 13 showing up in the mask. A live view that is held too long shows up as a non-zero read two clocks after a pulse.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
    localparam int REG_W       = 32;
    localparam int WORD_ADDR_W = 4;
    localparam int DONE_POS    = 1;
    localparam int ABORT_POS   = 13;

    localparam logic [REG_W-1:0] IMPL_BITS =
        (REG_W'(1) << DONE_POS) | (REG_W'(1) << ABORT_POS);

    localparam logic [WORD_ADDR_W-1:0] OFS_LIVE   = WORD_ADDR_W'(4);
    localparam logic [WORD_ADDR_W-1:0] OFS_LATCH  = WORD_ADDR_W'(5);
    localparam logic [WORD_ADDR_W-1:0] OFS_MASK   = WORD_ADDR_W'(6);
    localparam logic [WORD_ADDR_W-1:0] OFS_DETECT = WORD_ADDR_W'(7);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LIVE,
        SEL_LATCH,
        SEL_MASK,
        SEL_DETECT
    } reg_sel_e;
endpackage

// File: rtl/chan_irq_evmap.sv
module chan_irq_evmap
    import chan_irq_pkg::*;
#(
    parameter int W         = REG_W,
    parameter int DONE_BIT  = DONE_POS,
    parameter int ABORT_BIT = ABORT_POS
) (
    input  logic         done_evt,
    input  logic         abort_evt,
    output logic [W-1:0] evt_vec
);
    // An abort also ends the transfer, so it raises the done bit as well.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == ABORT_BIT) begin : g_abort
            assign evt_vec[i] = abort_evt;
        end else if (i == DONE_BIT) begin : g_done
            assign evt_vec[i] = done_evt | abort_evt;
        end else begin : g_unused
            assign evt_vec[i] = 1'b0;
        end
    end
endmodule

// File: rtl/chan_irq_reqbank.sv
module chan_irq_reqbank
    import chan_irq_pkg::*;
#(
    parameter int           W    = REG_W,
    parameter logic [W-1:0] IMPL = IMPL_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] req_q
);
    // Set has priority over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= (set_vec | (req_q & ~clr_vec)) & IMPL;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        if (IMPL[i]) begin : g_impl
            // R6: a set always lands, even against a clear
            p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
                set_vec[i] |=> req_q[i]);
            // R5: a clear without a set empties the bit
            p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!set_vec[i] && clr_vec[i]) |=> !req_q[i]);
            // R3: with neither set nor clear the bit is sticky
            p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (!set_vec[i] && !clr_vec[i]) |=> $stable(req_q[i]));
        end
    end
endmodule

// File: rtl/chan_irq_regport.sv
module chan_irq_regport
    import chan_irq_pkg::*;
#(
    parameter int           W    = REG_W,
    parameter int           AW   = WORD_ADDR_W,
    parameter logic [W-1:0] IMPL = IMPL_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  live_q,
    input  logic [W-1:0]  req_q,
    output logic [W-1:0]  clr_vec,
    output logic [W-1:0]  mask_q,
    output logic [W-1:0]  detect,
    output logic [W-1:0]  rdata
);
    reg_sel_e sel;

    always_comb begin
        unique case (addr)
            AW'(OFS_LIVE):   sel = SEL_LIVE;
            AW'(OFS_LATCH):  sel = SEL_LATCH;
            AW'(OFS_MASK):   sel = SEL_MASK;
            AW'(OFS_DETECT): sel = SEL_DETECT;
            default:         sel = SEL_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en && sel == SEL_MASK) begin
            mask_q <= wdata & IMPL;
        end
    end

    assign clr_vec = (wr_en && sel == SEL_LATCH) ? wdata : '0;
    assign detect  = req_q & mask_q;

    always_comb begin
        unique case (sel)
            SEL_LIVE:   rdata = live_q;
            SEL_LATCH:  rdata = req_q;
            SEL_MASK:   rdata = mask_q;
            SEL_DETECT: rdata = detect;
            SEL_NONE:   rdata = '0;
            default:    rdata = '0;
        endcase
    end

    // R7: the mask changes only on a write to its own offset
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == AW'(OFS_MASK)) |=> $stable(mask_q));
    // R10: unmapped offsets read as zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > AW'(OFS_DETECT) || addr < AW'(OFS_LIVE)) |-> (rdata == '0));
endmodule

// File: rtl/chan_irq_unit.sv
module chan_irq_unit
    import chan_irq_pkg::*;
#(
    parameter int W         = REG_W,
    parameter int AW        = WORD_ADDR_W,
    parameter int DONE_BIT  = DONE_POS,
    parameter int ABORT_BIT = ABORT_POS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_evt,
    input  logic          abort_evt,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    output logic          irq
);
    localparam logic [W-1:0] IMPL =
        (W'(1) << DONE_BIT) | (W'(1) << ABORT_BIT);

    logic [W-1:0] evt_vec;
    logic [W-1:0] live_q;
    logic [W-1:0] req_q;
    logic [W-1:0] clr_vec;
    logic [W-1:0] mask_q;
    logic [W-1:0] detect;

    chan_irq_evmap #(.W(W), .DONE_BIT(DONE_BIT), .ABORT_BIT(ABORT_BIT)) u_evmap (
        .done_evt  (done_evt),
        .abort_evt (abort_evt),
        .evt_vec   (evt_vec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= evt_vec & IMPL;
        end
    end

    chan_irq_reqbank #(.W(W), .IMPL(IMPL)) u_reqbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (evt_vec),
        .clr_vec (clr_vec),
        .req_q   (req_q)
    );

    chan_irq_regport #(.W(W), .AW(AW), .IMPL(IMPL)) u_regport (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .live_q  (live_q),
        .req_q   (req_q),
        .clr_vec (clr_vec),
        .mask_q  (mask_q),
        .detect  (detect),
        .rdata   (reg_rdata)
    );

    assign irq = |detect;

    // R4: an abort pulse latches both the abort and the done bit
    p_abort_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_evt |=> (req_q[ABORT_BIT] && req_q[DONE_BIT]));
    // R9: with nothing enabled the shared line stays low
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
    // R2: the live view clears one cycle after a quiet cycle
    p_live_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_evt && !abort_evt) |=> (live_q == '0));
endmodule

// File: tb/chan_irq_unit_test.sv
`timescale 1ns/1ps
module chan_irq_unit_test;
    localparam int CLK_HALF = 10; // 50 MHz
    localparam int NSTEP    = 17;

    typedef struct packed {
        logic [23:0] tag;
        logic        done;
        logic        abort;
        logic        wr;
        logic [3:0]  waddr;
        logic [31:0] wdata;
        logic [3:0]  raddr;
        logic [31:0] exp;
        logic        exp_irq;
    } step_t;

    localparam step_t TBL [NSTEP] = '{
        '{"R2 ", 1'b1, 1'b0, 1'b0, 4'd0, 32'h0,        4'd4, 32'h2,    1'b0}, // live shows done
        '{"R2 ", 1'b0, 1'b0, 1'b0, 4'd0, 32'h0,        4'd4, 32'h0,    1'b0}, // live cleared
        '{"R3 ", 1'b0, 1'b0, 1'b0, 4'd0, 32'h0,        4'd5, 32'h2,    1'b0}, // sticky latch
        '{"R7 ", 1'b0, 1'b0, 1'b1, 4'd6, 32'hFFFFFFFF, 4'd6, 32'h2002, 1'b1}, // mask keeps 1,13
        '{"R8 ", 1'b0, 1'b0, 1'b0, 4'd0, 32'h0,        4'd7, 32'h2,    1'b1}, // detect
        '{"R5 ", 1'b0, 1'b0, 1'b1, 4'd5, 32'h0,        4'd5, 32'h2,    1'b1}, // zero no effect
        '{"R5 ", 1'b0, 1'b0, 1'b1, 4'd5, 32'h2,        4'd5, 32'h0,    1'b0}, // W1C
        '{"R4 ", 1'b0, 1'b1, 1'b0, 4'd0, 32'h0,        4'd5, 32'h2002, 1'b1}, // abort sets both
        '{"R8 ", 1'b0, 1'b0, 1'b0, 4'd0, 32'h0,        4'd7, 32'h2002, 1'b1},
        '{"R9 ", 1'b0, 1'b0, 1'b1, 4'd6, 32'h2000,     4'd7, 32'h2000, 1'b1},
        '{"R9 ", 1'b0, 1'b0, 1'b1, 4'd5, 32'h2000,     4'd7, 32'h0,    1'b0}, // masked-out req
        '{"R2 ", 1'b0, 1'b0, 1'b1, 4'd4, 32'hFFFF,     4'd4, 32'h0,    1'b0}, // live read-only
        '{"R8 ", 1'b0, 1'b0, 1'b1, 4'd7, 32'hFFFFFFFF, 4'd5, 32'h2,    1'b0}, // detect read-only
        '{"R10", 1'b0, 1'b0, 1'b1, 4'd9, 32'hFFFFFFFF, 4'd6, 32'h2000, 1'b0}, // unmapped write
        '{"R10", 1'b0, 1'b0, 1'b0, 4'd0, 32'h0,        4'd9, 32'h0,    1'b0}, // unmapped read
        '{"R6 ", 1'b1, 1'b0, 1'b1, 4'd5, 32'h2,        4'd5, 32'h2,    1'b0}, // set beats clear
        '{"R6 ", 1'b0, 1'b1, 1'b1, 4'd5, 32'h2002,     4'd5, 32'h2002, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done_evt = 1'b0;
    logic        abort_evt = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_HALF) clk = ~clk;

    chan_irq_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_evt  (done_evt),
        .abort_evt (abort_evt),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_at(input logic [3:0] a, input string req, input logic [31:0] exp);
        @(negedge clk);
        reg_wr   = 1'b0;
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        #(CLK_HALF * 2 * 5000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        read_at(4'd4, "R1 live", 32'h0);
        read_at(4'd5, "R1 latch", 32'h0);
        read_at(4'd6, "R1 mask", 32'h0);
        read_at(4'd7, "R1 detect", 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        for (int s = 0; s < NSTEP; s++) begin
            @(negedge clk);
            done_evt  = TBL[s].done;
            abort_evt = TBL[s].abort;
            reg_wr    = TBL[s].wr;
            reg_addr  = TBL[s].waddr;
            reg_wdata = TBL[s].wdata;
            @(negedge clk);
            done_evt  = 1'b0;
            abort_evt = 1'b0;
            reg_wr    = 1'b0;
            reg_addr  = TBL[s].raddr;
            #1;
            chk($sformatf("%s step %0d data", TBL[s].tag, s), reg_rdata, TBL[s].exp);
            chk($sformatf("%s step %0d irq", TBL[s].tag, s), {31'd0, irq}, {31'd0, TBL[s].exp_irq});
        end

        // R4: abort bit pollable one cycle after the pulse
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'd5; reg_wdata = 32'hFFFFFFFF;
        @(negedge clk);
        reg_wr = 1'b0; abort_evt = 1'b1;
        @(negedge clk);
        abort_evt = 1'b0; reg_addr = 4'd5;
        #1;
        chk("R4 poll", reg_rdata & 32'h2000, 32'h2000);

        // R1: reset mid-run wipes everything
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 irq in reset", {31'd0, irq}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        read_at(4'd5, "R1 latch after reset", 32'h0);
        read_at(4'd6, "R1 mask after reset", 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule